// File: doc/BRIEF.md
# Buffered synchronous serial port

This block is a full-duplex synchronous serial port. A host writes words into a transmit data register and reads received words from a receive data register. Each direction has its own serial clock, frame sync and data line. All six serial pins are inputs except the transmit data line. The serial clocks come from outside the block.

Serial clocks, frame syncs and receive data are brought into the host clock domain through two-flop synchronizers. The rising edges of each serial clock are detected in that domain, and all shifting happens on those host cycles. For this to work, each high phase and each low phase of a serial clock must last at least two host clock periods.

Word length and frame length are set per direction. Each set of length inputs must be held steady while a frame is in progress in that direction. Received words pass through a shift register, then a buffer register, then the host-readable register. Ready flags and one-cycle event pulses let a DMA engine keep pace with the port. Overrun and underflow are recorded in sticky flags.

Top module: `bsp_port`

## Requirements
- R1: A 3-bit word-length code selects the bits per word: code 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and codes 5, 6 and 7 give 32.
- R2: A 7-bit frame-length field holds the number of words minus one, giving 1 to 128 words per frame. A frame's words follow each other with no gap, and only one frame sync precedes them.
- R3: Transmit starts when the frame sync is seen high at a detected transmit clock rising edge while the transmitter is idle. The MSB of the first word is driven after that edge, and the next bit after each later rising edge, MSB first. A frame sync during an active frame is ignored. The data line is low when idle.
- R4: Receive starts when the frame sync is seen high at a detected receive clock rising edge while the receiver is idle. The first bit is sampled at the next rising edge, then one bit per rising edge, MSB first. Words narrower than 32 bits are right-justified with zeros above.
- R5: A completed word goes into the buffer register. It moves on to the host data register only while the receive-ready flag is clear. The move sets receive-ready, and a one-cycle receive event is issued in the same cycle that ready rises.
- R6: A read pulse clears receive-ready on the next cycle. A word waiting in the buffer register then reaches the data register one cycle later.
- R7: If a word completes while both the data register and the buffer register hold unread words, the overrun flag sets and the new word is discarded. The unread words stay unchanged. A read clears the overrun flag.
- R8: Each copy of the transmit data register into the shift register sets transmit-ready and issues a one-cycle transmit event. A write clears transmit-ready on the next cycle, and the write takes priority if both happen together.
- R9: If a copy happens while transmit-ready is already set, the underflow flag sets and the previous word is sent again. A write clears the underflow flag.
- R10: After reset, transmit-ready is 1. Receive-ready, both events, both flags, the serial data output and the receive data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Write pulse for the transmit data register |
| tx_wdata | input | 32 | Transmit word, right-justified |
| tx_wlen | input | 3 | Transmit word-length code |
| tx_flen | input | FW | Transmit words per frame minus one |
| tx_ready | output | 1 | Transmit data register may be written |
| tx_event | output | 1 | One-cycle DMA request for transmit |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_rd | input | 1 | Read pulse for the receive data register |
| rx_rdata | output | 32 | Receive data register |
| rx_wlen | input | 3 | Receive word-length code |
| rx_flen | input | FW | Receive words per frame minus one |
| rx_ready | output | 1 | Receive data register holds an unread word |
| rx_event | output | 1 | One-cycle DMA request for receive |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_sclk | input | 1 | Transmit serial clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_dout | output | 1 | Transmit serial data |
| rx_sclk | input | 1 | Receive serial clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_din | input | 1 | Receive serial data |

## Verification
The hardest state to reach from the ports is overrun. It needs two unread words stacked in the buffer and data registers while a third word completes. The bench gets there by holding back reads during a four-word loopback frame. It then reads one word at a time to watch the buffered word advance. Underflow is reached the same way: only one word is supplied for a three-word frame, which forces the re-send path.

// File: rtl/bsp_port.sv
module bsp_port #(
  parameter int FW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr,
  input  logic [31:0]   tx_wdata,
  input  logic [2:0]    tx_wlen,
  input  logic [FW-1:0] tx_flen,
  output logic          tx_ready,
  output logic          tx_event,
  output logic          tx_underflow,
  input  logic          rx_rd,
  output logic [31:0]   rx_rdata,
  input  logic [2:0]    rx_wlen,
  input  logic [FW-1:0] rx_flen,
  output logic          rx_ready,
  output logic          rx_event,
  output logic          rx_overrun,
  input  logic          tx_sclk,
  input  logic          tx_fs,
  output logic          tx_dout,
  input  logic          rx_sclk,
  input  logic          rx_fs,
  input  logic          rx_din
);

  function automatic logic [5:0] wbits(input logic [2:0] c);
    case (c)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // transmit side
  logic [2:0]    txc_q;
  logic [1:0]    txf_q;
  logic          tx_act;
  logic [5:0]    tx_bit;
  logic [FW-1:0] tx_word;
  logic [31:0]   tx_sr, tx_dr;

  wire        tx_rise     = txc_q[1] & ~txc_q[2];
  wire [5:0]  tx_n        = wbits(tx_wlen);
  wire        tx_last_bit = (tx_bit == tx_n);
  wire        tx_load     = tx_rise & ((~tx_act & txf_q[1]) |
                                       (tx_act & tx_last_bit & (tx_word != tx_flen)));
  wire [31:0] tx_al       = tx_dr << (6'd32 - tx_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_q   <= '0;
      txf_q   <= '0;
      tx_act  <= 1'b0;
      tx_bit  <= '0;
      tx_word <= '0;
      tx_sr   <= '0;
      tx_dout <= 1'b0;
    end else begin
      txc_q <= {txc_q[1:0], tx_sclk};
      txf_q <= {txf_q[0], tx_fs};
      if (tx_load) begin
        tx_act  <= 1'b1;
        tx_bit  <= 6'd1;
        tx_word <= tx_act ? tx_word + 1'b1 : '0;
        tx_dout <= tx_al[31];
        tx_sr   <= tx_al << 1;
      end else if (tx_rise && tx_act) begin
        if (tx_last_bit) begin
          tx_act  <= 1'b0;
          tx_dout <= 1'b0;
        end else begin
          tx_dout <= tx_sr[31];
          tx_sr   <= tx_sr << 1;
          tx_bit  <= tx_bit + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dr        <= '0;
      tx_ready     <= 1'b1;
      tx_event     <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      tx_event <= tx_load;
      if (tx_wr) begin
        tx_dr    <= tx_wdata;
        tx_ready <= 1'b0;
      end else if (tx_load) begin
        tx_ready <= 1'b1;
      end
      if (tx_load && tx_ready) tx_underflow <= 1'b1;
      else if (tx_wr)          tx_underflow <= 1'b0;
    end
  end

  // receive side
  logic [2:0]    rxc_q;
  logic [1:0]    rxf_q, rxd_q;
  logic          rx_act, rbr_full;
  logic [5:0]    rx_bit;
  logic [FW-1:0] rx_word;
  logic [31:0]   rx_sr, rbr;

  wire        rx_rise = rxc_q[1] & ~rxc_q[2];
  wire [5:0]  rx_n    = wbits(rx_wlen);
  wire [31:0] rx_next = {rx_sr[30:0], rxd_q[1]};
  wire        rx_done = rx_rise & rx_act & ((rx_bit + 6'd1) == rx_n);
  wire        rx_load = rbr_full & ~rx_ready;
  wire        rx_keep = rx_done & (~rbr_full | rx_load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_q   <= '0;
      rxf_q   <= '0;
      rxd_q   <= '0;
      rx_act  <= 1'b0;
      rx_bit  <= '0;
      rx_word <= '0;
      rx_sr   <= '0;
    end else begin
      rxc_q <= {rxc_q[1:0], rx_sclk};
      rxf_q <= {rxf_q[0], rx_fs};
      rxd_q <= {rxd_q[0], rx_din};
      if (rx_rise) begin
        if (!rx_act) begin
          if (rxf_q[1]) begin
            rx_act  <= 1'b1;
            rx_bit  <= '0;
            rx_word <= '0;
            rx_sr   <= '0;
          end
        end else if (rx_done) begin
          rx_sr  <= '0;
          rx_bit <= '0;
          if (rx_word == rx_flen) rx_act  <= 1'b0;
          else                    rx_word <= rx_word + 1'b1;
        end else begin
          rx_sr  <= rx_next;
          rx_bit <= rx_bit + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr        <= '0;
      rbr_full   <= 1'b0;
      rx_rdata   <= '0;
      rx_ready   <= 1'b0;
      rx_event   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      rx_event <= rx_load;
      if (rx_load) begin
        rx_rdata <= rbr;
        rx_ready <= 1'b1;
      end else if (rx_rd) begin
        rx_ready <= 1'b0;
      end
      if (rx_keep) begin
        rbr      <= rx_next;
        rbr_full <= 1'b1;
      end else if (rx_load) begin
        rbr_full <= 1'b0;
      end
      if (rx_done && !rx_keep) rx_overrun <= 1'b1;
      else if (rx_rd)          rx_overrun <= 1'b0;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_act |-> !tx_dout); // R3
  AST_RX_EVENT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> $rose(rx_ready)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && rx_ready |=> !rx_ready); // R6
  AST_HELD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rx_rd |=> rx_ready && $stable(rx_rdata)); // R7
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_ready); // R8
  AST_TX_EVENT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_event && !$past(tx_wr) |-> tx_ready); // R8

endmodule

// File: tb/bsp_port_bench.sv
`timescale 1ns/1ps
module bsp_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tx_wr = 1'b0, rx_rd = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic [2:0]  tx_wlen = '0, rx_wlen = '0;
  logic [6:0]  tx_flen = '0, rx_flen = '0;
  logic        scl = 1'b0, fs = 1'b0;
  logic        tx_ready, tx_event, tx_underflow, rx_ready, rx_event, rx_overrun, tx_dout;
  logic [31:0] rx_rdata;

  bsp_port u_bsp_port (
    .clk(clk), .rst_n(rst_n),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_wlen(tx_wlen), .tx_flen(tx_flen),
    .tx_ready(tx_ready), .tx_event(tx_event), .tx_underflow(tx_underflow),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_wlen(rx_wlen), .rx_flen(rx_flen),
    .rx_ready(rx_ready), .rx_event(rx_event), .rx_overrun(rx_overrun),
    .tx_sclk(scl), .tx_fs(fs), .tx_dout(tx_dout),
    .rx_sclk(scl), .rx_fs(fs), .rx_din(tx_dout)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits(input logic [2:0] c);
    return (c >= 3'd5) ? 32 : 8 + 4 * int'(c);
  endfunction

  int sc = 0;
  always @(negedge clk) begin
    if (sc == 3) begin sc = 0; scl = ~scl; end
    else sc++;
  end

  // behavioural reference model
  bit [2:0] m_tc, m_rc;
  bit [1:0] m_tf, m_rf, m_rd;
  bit m_tact, m_dout, m_tready = 1'b1, m_tev, m_und;
  bit m_ract, m_rready, m_rev, m_ovr;
  int m_tbi, m_twi, m_rbi, m_rwi;
  logic [31:0] m_cur, m_tdr, m_acc, m_drr;
  logic [31:0] m_buf[$];

  task automatic model_reset();
    m_tc = '0; m_rc = '0; m_tf = '0; m_rf = '0; m_rd = '0;
    m_tact = 0; m_dout = 0; m_tready = 1; m_tev = 0; m_und = 0;
    m_ract = 0; m_rready = 0; m_rev = 0; m_ovr = 0;
    m_tbi = 0; m_twi = 0; m_rbi = 0; m_rwi = 0;
    m_cur = '0; m_tdr = '0; m_acc = '0; m_drr = '0;
    m_buf.delete();
  endtask

  task automatic model_step();
    bit trise, rrise, tfs, rfs, rdb, done, ev, tr_pre, load, dropped;
    int n;
    logic [31:0] word;
    word = '0;
    rrise = m_rc[1] & ~m_rc[2]; rfs = m_rf[1]; rdb = m_rd[1];
    m_rc = {m_rc[1:0], scl}; m_rf = {m_rf[0], fs}; m_rd = {m_rd[0], m_dout};
    done = 0;
    n = nbits(rx_wlen);
    if (rrise) begin
      if (!m_ract) begin
        if (rfs) begin m_ract = 1; m_rbi = 0; m_rwi = 0; m_acc = '0; end
      end else begin
        m_acc = {m_acc[30:0], rdb};
        m_rbi++;
        if (m_rbi == n) begin
          done = 1; word = m_acc; m_acc = '0; m_rbi = 0;
          if (m_rwi == int'(rx_flen)) m_ract = 0; else m_rwi++;
        end
      end
    end
    load = (m_buf.size() > 0) && !m_rready;
    m_rev = load;
    if (load) begin m_drr = m_buf.pop_front(); m_rready = 1; end
    else if (rx_rd) m_rready = 0;
    dropped = done && (m_buf.size() != 0);
    if (done && !dropped) m_buf.push_back(word);
    if (dropped) m_ovr = 1; else if (rx_rd) m_ovr = 0;

    trise = m_tc[1] & ~m_tc[2]; tfs = m_tf[1];
    m_tc = {m_tc[1:0], scl}; m_tf = {m_tf[0], fs};
    n = nbits(tx_wlen);
    ev = 0;
    if (trise) begin
      if (!m_tact) begin
        if (tfs) begin m_tact = 1; m_twi = 0; ev = 1; end
      end else if (m_tbi < n) begin
        m_dout = m_cur[n-1-m_tbi]; m_tbi++;
      end else if (m_twi == int'(tx_flen)) begin
        m_tact = 0; m_dout = 0;
      end else begin
        m_twi++; ev = 1;
      end
      if (ev) begin m_cur = m_tdr; m_dout = m_tdr[n-1]; m_tbi = 1; end
    end
    tr_pre = m_tready;
    m_tev = ev;
    if (ev && tr_pre) m_und = 1; else if (tx_wr) m_und = 0;
    if (tx_wr) begin m_tdr = tx_wdata; m_tready = 0; end
    else if (ev) m_tready = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 tx_dout", {31'd0, tx_dout}, {31'd0, m_dout});
      chk("R8 tx_ready", {31'd0, tx_ready}, {31'd0, m_tready});
      chk("R8 tx_event", {31'd0, tx_event}, {31'd0, m_tev});
      chk("R9 tx_underflow", {31'd0, tx_underflow}, {31'd0, m_und});
      chk("R5 rx_ready", {31'd0, rx_ready}, {31'd0, m_rready});
      chk("R5 rx_event", {31'd0, rx_event}, {31'd0, m_rev});
      chk("R7 rx_overrun", {31'd0, rx_overrun}, {31'd0, m_ovr});
      chk("R4 rx_rdata", rx_rdata, m_drr);
    end
  end

  // host agent: writes queued words on ready, reads on ready
  logic [31:0] wq[$];
  logic [31:0] got[$];
  bit auto_rd = 1'b1;
  int rd_tickets = 0, rd_used = 0;

  always @(negedge clk) begin
    tx_wr = 1'b0;
    rx_rd = 1'b0;
    if (rst_n) begin
      if (tx_ready && wq.size() > 0) begin
        tx_wr = 1'b1;
        tx_wdata = wq.pop_front();
      end
      if (rx_ready && (auto_rd || rd_tickets > rd_used)) begin
        rx_rd = 1'b1;
        got.push_back(rx_rdata);
        if (!auto_rd) rd_used++;
      end
    end
  end

  task automatic frame(input int words, input int bits, input bit midfs);
    @(negedge scl); fs = 1'b1;
    @(negedge scl); fs = 1'b0;
    if (midfs) begin
      repeat (bits) @(negedge scl);
      fs = 1'b1;
      @(negedge scl); fs = 1'b0;
    end
    repeat (words * bits + 4) @(negedge scl);
    repeat (8) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] code, input logic [6:0] fl);
    tx_wlen = code; rx_wlen = code; tx_flen = fl; rx_flen = fl;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    chk("R10 tx_ready", {31'd0, tx_ready}, 32'd1);
    chk("R10 rx_ready", {31'd0, rx_ready}, 32'd0);
    chk("R10 flags", {30'd0, tx_underflow, rx_overrun}, 32'd0);
    chk("R10 events", {30'd0, tx_event, rx_event}, 32'd0);
    chk("R10 tx_dout", {31'd0, tx_dout}, 32'd0);
    chk("R10 rx_rdata", rx_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R2 R4: three 8-bit words in one frame
    cfg(3'd0, 7'd2);
    got.delete();
    wq.push_back(32'hA5); wq.push_back(32'h3C); wq.push_back(32'h81);
    frame(3, 8, 1'b0);
    chk("R2 word count", got.size(), 32'd3);
    if (got.size() == 3) begin
      chk("R1 8-bit w0", got[0], 32'hA5);
      chk("R1 8-bit w1", got[1], 32'h3C);
      chk("R4 8-bit w2", got[2], 32'h81);
    end

    // R3: frame sync inside an active frame is ignored; 12-bit words
    cfg(3'd1, 7'd1);
    got.delete();
    wq.push_back(32'hABC); wq.push_back(32'h5F0);
    frame(2, 12, 1'b1);
    chk("R3 word count with mid-frame sync", got.size(), 32'd2);
    if (got.size() == 2) begin
      chk("R3 12-bit w0", got[0], 32'hABC);
      chk("R1 12-bit w1", got[1], 32'h5F0);
    end
    chk("R3 idle dout low", {31'd0, tx_dout}, 32'd0);

    // R1: code 5 and code 7 both give 32 bits
    cfg(3'd5, 7'd0);
    got.delete();
    wq.push_back(32'hDEADBEEF);
    frame(1, 32, 1'b0);
    chk("R1 code5 32-bit", (got.size() == 1) ? got[0] : 32'hFFFF_FFFF, 32'hDEADBEEF);
    cfg(3'd7, 7'd0);
    got.delete();
    wq.push_back(32'h12345678);
    frame(1, 32, 1'b0);
    chk("R1 code7 32-bit", (got.size() == 1) ? got[0] : 32'hFFFF_FFFF, 32'h12345678);

    // R4: 16-bit word, upper bits dropped on send, zero-filled on receive
    cfg(3'd2, 7'd0);
    got.delete();
    wq.push_back(32'hFFFF9A5C);
    frame(1, 16, 1'b0);
    chk("R4 zero fill", (got.size() == 1) ? got[0] : 32'hFFFF_FFFF, 32'h00009A5C);

    // R7 R6: no reads during a four-word 20-bit frame
    auto_rd = 1'b0;
    cfg(3'd3, 7'd3);
    got.delete();
    wq.push_back(32'h11111); wq.push_back(32'h22222);
    wq.push_back(32'h33333); wq.push_back(32'h44444);
    frame(4, 20, 1'b0);
    chk("R7 oldest word held", rx_rdata, 32'h11111);
    chk("R7 ready held", {31'd0, rx_ready}, 32'd1);
    chk("R7 overrun set", {31'd0, rx_overrun}, 32'd1);
    rd_tickets++;
    repeat (4) @(negedge clk);
    chk("R6 buffered word advanced", rx_rdata, 32'h22222);
    chk("R6 ready again", {31'd0, rx_ready}, 32'd1);
    chk("R7 overrun cleared by read", {31'd0, rx_overrun}, 32'd0);
    rd_tickets++;
    repeat (4) @(negedge clk);
    chk("R6 no more words", {31'd0, rx_ready}, 32'd0);
    chk("R6 read words", got.size(), 32'd2);
    auto_rd = 1'b1;

    // R9: one word supplied for a three-word frame
    cfg(3'd2, 7'd2);
    got.delete();
    wq.push_back(32'hBEEF);
    frame(3, 16, 1'b0);
    chk("R9 underflow set", {31'd0, tx_underflow}, 32'd1);
    chk("R9 resend count", got.size(), 32'd3);
    for (int i = 0; i < got.size(); i++) chk("R9 resent word", got[i], 32'hBEEF);
    wq.push_back(32'h1234);
    repeat (4) @(negedge clk);
    chk("R9 write clears underflow", {31'd0, tx_underflow}, 32'd0);
    chk("R8 write clears ready", {31'd0, tx_ready}, 32'd0);

    // R2: longest frame, 128 words of 8 bits
    cfg(3'd0, 7'd127);
    got.delete();
    for (int i = 1; i < 128; i++) wq.push_back((i * 7 + 3) & 32'hFF);
    frame(128, 8, 1'b0);
    chk("R2 128-word count", got.size(), 32'd128);
    if (got.size() == 128) begin
      chk("R2 first of long frame", got[0], 32'h34);
      for (int i = 1; i < 128; i++) chk("R2 long frame word", got[i], (i * 7 + 3) & 32'hFF);
    end
    chk("R9 no underflow in fed frame", {31'd0, tx_underflow}, 32'd0);

    summary();
    $finish;
  end
endmodule